// File: doc/BRIEF.md
# System Register Access Router

This block settles the outcome of a move to or from a system register. A request names the register with five encoding fields (op0, op1, CRn, CRm, op2). It also carries a read/write flag, the privilege level of the requester (0 to 3) and the write data. The block holds two translation base registers: a guest-level one (the "low" register) and a hypervisor one.

Each accepted request ends in exactly one of four outcomes:

- the access completes on a physical register;
- the access is undefined;
- the access traps to level 2 with a syndrome class;
- the access is redirected to a fixed offset in a memory save area.

For the low encoding, the outcome depends on the level and on a set of virtualisation controls. These controls are tested in a fixed priority. The access to memory itself happens elsewhere.

Requests enter over a valid/ready channel and outcomes leave over a second valid/ready channel. The request side is ready whenever the response slot is empty or is being drained in the same cycle. A response that is not taken stays on the outputs, unchanged, until `rsp_ready` is seen high. The control inputs are plain levels and are sampled in the cycle a request is accepted.

Top module: `sysreg_route_arbiter`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and both registers read back as zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` equals `!rsp_valid || rsp_ready`. The response is valid one clock after acceptance and holds all its output values until it is taken with `rsp_ready`.
- R3: `rsp_status` is one-hot: bit 0 ok, bit 1 undefined, bit 2 trap, bit 3 redirect. `rsp_class` is 0x18 on a trap and 0 otherwise. `rsp_offset` is 0x210 on a redirect and 0 otherwise. `rsp_rdata` is zero unless the outcome is an ok read.
- R4: The hypervisor register is encoded as op0=3, op1=4, CRn=2, CRm=0, op2=1. The low register uses the same fields except op1=0. Any other encoding is undefined.
- R5: Every access from level 0 is undefined.
- R6: At level 1, the hypervisor encoding traps when `ctl_l2_on` and `ctl_nv` are both 1, and is undefined otherwise.
- R7: A level-1 read of the low encoding with `ctl_l2_on`=1 is resolved by the first matching rule, checked in this order:
  - `ctl_vm_rd_trap` gives a trap;
  - `ctl_fg_rd_trap` gives a trap when `ctl_top_present`=0 or `ctl_fg_en`=1;
  - `ctl_nv`, `ctl_nv1` and `ctl_nv2` all set give a redirect;
  - otherwise the low register is read.

  With `ctl_l2_on`=0, the read goes to the low register.
- R8: Level-1 writes of the low encoding follow the same order as R7, using `ctl_vm_wr_trap` and `ctl_fg_wr_trap`.
- R9: At level 2, the low encoding reaches the hypervisor register when `ctl_host_ext`=1 and the low register otherwise. At levels 2 and 3, the hypervisor encoding reaches the hypervisor register.
- R10: At level 3, the low encoding always reaches the low register, whatever the controls.
- R11: A register takes `req_wdata` in full only on an ok write. Later ok reads of that register return the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Privilege level of the requester |
| req_wdata | input | DW | Write data |
| ctl_host_ext | input | 1 | Host extension enabled at level 2 |
| ctl_nv | input | 1 | Nested virtualisation bit |
| ctl_nv1 | input | 1 | Nested virtualisation bit 1 |
| ctl_nv2 | input | 1 | Nested virtualisation bit 2 |
| ctl_vm_rd_trap | input | 1 | Trap level-1 reads of virtual-memory controls |
| ctl_vm_wr_trap | input | 1 | Trap level-1 writes of virtual-memory controls |
| ctl_fg_rd_trap | input | 1 | Fine-grained read trap for the low register |
| ctl_fg_wr_trap | input | 1 | Fine-grained write trap for the low register |
| ctl_fg_en | input | 1 | Fine-grained traps enabled by level 3 |
| ctl_top_present | input | 1 | Level 3 is implemented |
| ctl_l2_on | input | 1 | Level 2 is enabled |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 4 | One-hot outcome |
| rsp_rdata | output | DW | Read data |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_offset | output | 12 | Redirect offset |

## Verification
The bench sweeps every combination of the eleven control bits against all four levels, both register encodings, eight near-miss encodings, and reads and writes. A reference model in the bench predicts each outcome and tracks both registers.

The targeted corners are these:

- The level-1 priority chain. Swapping the virtual-memory trap and the fine-grained trap changes nothing visible, but letting the redirect win over either trap turns expected traps into redirects.
- The fine-grained gate. Ignoring `ctl_top_present` or `ctl_fg_en` traps when the access should complete.
- The level-2 host-extension steering. Getting it wrong sends data to the wrong register, which shows up on a later read.
- Writes on trap or redirect. A design that commits these corrupts the register the model still holds.
- A single-field encoding mismatch. A design that decodes too few fields completes an access that should be undefined.

A stalled response is held for several cycles while a second request waits, to show that nothing changes and nothing is accepted.

// File: rtl/srt_pkg.sv
package srt_pkg;

  // Outcome codes double as the bit index into the one-hot status.
  typedef enum logic [1:0] {
    OUT_OK    = 2'd0,
    OUT_UNDEF = 2'd1,
    OUT_TRAP  = 2'd2,
    OUT_REDIR = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LOW  = 2'd1,
    TGT_HYP  = 2'd2
  } target_e;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } enc_t;

  typedef struct packed {
    logic host_ext;
    logic nv;
    logic nv1;
    logic nv2;
    logic vm_rd_trap;
    logic vm_wr_trap;
    logic fg_rd_trap;
    logic fg_wr_trap;
    logic fg_en;
    logic top_present;
    logic l2_on;
  } ctl_t;

  localparam enc_t ENC_HYP = '{op0: 2'b11, op1: 3'b100, crn: 4'b0010, crm: 4'b0000, op2: 3'b001};
  localparam enc_t ENC_LOW = '{op0: 2'b11, op1: 3'b000, crn: 4'b0010, crm: 4'b0000, op2: 3'b001};

endpackage

// File: rtl/srt_decode.sv
module srt_decode
  import srt_pkg::*;
(
  input  enc_t       enc,
  input  logic [1:0] level,
  input  logic       write,
  input  ctl_t       ctl,
  output outcome_e   outcome,
  output target_e    target
);

  logic hit_hyp;
  logic hit_low;
  logic vm_trap;
  logic fg_trap;
  logic nested_all;

  assign hit_hyp    = (enc == ENC_HYP);
  assign hit_low    = (enc == ENC_LOW);
  assign vm_trap    = write ? ctl.vm_wr_trap : ctl.vm_rd_trap;
  assign fg_trap    = (write ? ctl.fg_wr_trap : ctl.fg_rd_trap) &&
                      (!ctl.top_present || ctl.fg_en);
  assign nested_all = ctl.nv && ctl.nv1 && ctl.nv2;

  always_comb begin
    outcome = OUT_UNDEF;
    target  = TGT_NONE;
    if (level == 2'd0 || !(hit_hyp || hit_low)) begin
      outcome = OUT_UNDEF;
    end else if (hit_hyp) begin
      if (level == 2'd1) begin
        outcome = (ctl.l2_on && ctl.nv) ? OUT_TRAP : OUT_UNDEF;
      end else begin
        outcome = OUT_OK;
        target  = TGT_HYP;
      end
    end else begin
      unique case (level)
        2'd1: begin
          if (!ctl.l2_on) begin
            outcome = OUT_OK;
            target  = TGT_LOW;
          end else if (vm_trap) begin
            outcome = OUT_TRAP;
          end else if (fg_trap) begin
            outcome = OUT_TRAP;
          end else if (nested_all) begin
            outcome = OUT_REDIR;
          end else begin
            outcome = OUT_OK;
            target  = TGT_LOW;
          end
        end
        2'd2: begin
          outcome = OUT_OK;
          target  = ctl.host_ext ? TGT_HYP : TGT_LOW;
        end
        default: begin
          outcome = OUT_OK;
          target  = TGT_LOW;
        end
      endcase
    end
  end

endmodule

// File: rtl/srt_bank.sv
module srt_bank #(
  parameter int DW   = 64,
  parameter int NREG = 2,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        regs[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IW'(i)) rd_data = regs[i];
    end
  end

endmodule

// File: rtl/srt_resp.sv
module srt_resp
  import srt_pkg::*;
#(
  parameter int             DW         = 64,
  parameter int             CLASS_W    = 6,
  parameter int             OFS_W      = 12,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
  parameter logic [OFS_W-1:0]   REDIR_OFS  = 12'h210
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               drain,
  input  outcome_e           outcome,
  input  logic               is_write,
  input  logic [DW-1:0]      rd_data,
  output logic               valid,
  output logic [3:0]         status,
  output logic [DW-1:0]      rdata,
  output logic [CLASS_W-1:0] class_o,
  output logic [OFS_W-1:0]   offset
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      status  <= '0;
      rdata   <= '0;
      class_o <= '0;
      offset  <= '0;
    end else if (accept) begin
      valid   <= 1'b1;
      status  <= 4'b0001 << outcome;
      rdata   <= (outcome == OUT_OK && !is_write) ? rd_data : '0;
      class_o <= (outcome == OUT_TRAP) ? TRAP_CLASS : '0;
      offset  <= (outcome == OUT_REDIR) ? REDIR_OFS : '0;
    end else if (drain) begin
      valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/sysreg_route_arbiter.sv
module sysreg_route_arbiter
  import srt_pkg::*;
#(
  parameter int DW      = 64,
  parameter int CLASS_W = 6,
  parameter int OFS_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op0,
  input  logic [2:0]         req_op1,
  input  logic [3:0]         req_crn,
  input  logic [3:0]         req_crm,
  input  logic [2:0]         req_op2,
  input  logic               req_write,
  input  logic [1:0]         req_level,
  input  logic [DW-1:0]      req_wdata,
  input  logic               ctl_host_ext,
  input  logic               ctl_nv,
  input  logic               ctl_nv1,
  input  logic               ctl_nv2,
  input  logic               ctl_vm_rd_trap,
  input  logic               ctl_vm_wr_trap,
  input  logic               ctl_fg_rd_trap,
  input  logic               ctl_fg_wr_trap,
  input  logic               ctl_fg_en,
  input  logic               ctl_top_present,
  input  logic               ctl_l2_on,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [3:0]         rsp_status,
  output logic [DW-1:0]      rsp_rdata,
  output logic [CLASS_W-1:0] rsp_class,
  output logic [OFS_W-1:0]   rsp_offset
);

  localparam int NREG = 2;
  localparam int IW   = $clog2(NREG);

  enc_t          enc;
  ctl_t          ctl;
  outcome_e      outcome;
  target_e       target;
  logic          accept;
  logic          wr_en;
  logic [IW-1:0] reg_idx;
  logic [DW-1:0] bank_rdata;

  assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
  assign ctl = '{host_ext: ctl_host_ext, nv: ctl_nv, nv1: ctl_nv1, nv2: ctl_nv2,
                 vm_rd_trap: ctl_vm_rd_trap, vm_wr_trap: ctl_vm_wr_trap,
                 fg_rd_trap: ctl_fg_rd_trap, fg_wr_trap: ctl_fg_wr_trap,
                 fg_en: ctl_fg_en, top_present: ctl_top_present, l2_on: ctl_l2_on};

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write && (outcome == OUT_OK);
  assign reg_idx   = (target == TGT_HYP) ? IW'(1) : IW'(0);

  srt_decode u_decode (
    .enc     (enc),
    .level   (req_level),
    .write   (req_write),
    .ctl     (ctl),
    .outcome (outcome),
    .target  (target)
  );

  srt_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (reg_idx),
    .wr_data (req_wdata),
    .rd_idx  (reg_idx),
    .rd_data (bank_rdata)
  );

  srt_resp #(.DW(DW), .CLASS_W(CLASS_W), .OFS_W(OFS_W),
             .TRAP_CLASS(CLASS_W'(6'h18)), .REDIR_OFS(OFS_W'(12'h210))) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .drain    (rsp_ready),
    .outcome  (outcome),
    .is_write (req_write),
    .rd_data  (bank_rdata),
    .valid    (rsp_valid),
    .status   (rsp_status),
    .rdata    (rsp_rdata),
    .class_o  (rsp_class),
    .offset   (rsp_offset)
  );

endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int DW      = 64,
  parameter int CLASS_W = 6,
  parameter int OFS_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [1:0]         req_level,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [3:0]         rsp_status,
  input logic [DW-1:0]      rsp_rdata,
  input logic [CLASS_W-1:0] rsp_class,
  input logic [OFS_W-1:0]   rsp_offset
);

  logic last_wr;
  logic took;

  assign took = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_wr <= 1'b0;
    else if (took) last_wr <= req_write;
  end

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R2
  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> rsp_valid); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata)
                                   && $stable(rsp_class) && $stable(rsp_offset))); // R2
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot(rsp_status)); // R3
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_class == CLASS_W'(6'h18)) == rsp_status[2])); // R3
  AST_REDIR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_offset == OFS_W'(12'h210)) == rsp_status[3])); // R3
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (!rsp_status[0] || last_wr)) |-> (rsp_rdata == '0)); // R3
  AST_LEVEL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (took && req_level == 2'd0) |=> (rsp_status == 4'b0010)); // R5

endmodule

bind sysreg_route_arbiter srt_checker #(.DW(DW), .CLASS_W(CLASS_W), .OFS_W(OFS_W)) u_srt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_level  (req_level),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .rsp_rdata  (rsp_rdata),
  .rsp_class  (rsp_class),
  .rsp_offset (rsp_offset)
);

// File: tb/sysreg_route_arbiter_test.sv
module sysreg_route_arbiter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op0 = '0;
  logic [2:0]  req_op1 = '0;
  logic [3:0]  req_crn = '0;
  logic [3:0]  req_crm = '0;
  logic [2:0]  req_op2 = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_level = '0;
  logic [63:0] req_wdata = '0;
  logic [10:0] ctl = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [3:0]  rsp_status;
  logic [63:0] rsp_rdata;
  logic [5:0]  rsp_class;
  logic [11:0] rsp_offset;

  int checks = 0;
  int errors = 0;
  logic [63:0] model_low = '0;
  logic [63:0] model_hyp = '0;

  always #10 clk = ~clk;

  sysreg_route_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_write(req_write), .req_level(req_level), .req_wdata(req_wdata),
    .ctl_host_ext(ctl[0]), .ctl_nv(ctl[1]), .ctl_nv1(ctl[2]), .ctl_nv2(ctl[3]),
    .ctl_vm_rd_trap(ctl[4]), .ctl_vm_wr_trap(ctl[5]), .ctl_fg_rd_trap(ctl[6]),
    .ctl_fg_wr_trap(ctl[7]), .ctl_fg_en(ctl[8]), .ctl_top_present(ctl[9]), .ctl_l2_on(ctl[10]),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .rsp_class(rsp_class), .rsp_offset(rsp_offset)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // enc_sel: 0 low, 1 hypervisor, 2 single-field mismatch chosen by var
  task automatic set_enc(input int enc_sel, input logic [2:0] var_sel);
    req_op0 = 2'b11; req_op1 = (enc_sel == 1) ? 3'b100 : 3'b000;
    req_crn = 4'b0010; req_crm = 4'b0000; req_op2 = 3'b001;
    if (enc_sel == 2) begin
      case (var_sel)
        3'd0: req_op0 = 2'b10;
        3'd1: req_op0 = 2'b00;
        3'd2: req_op1 = 3'b101;
        3'd3: req_op1 = 3'b001;
        3'd4: req_crn = 4'b0011;
        3'd5: req_crm = 4'b0001;
        3'd6: req_op2 = 3'b000;
        default: req_op2 = 3'b010;
      endcase
    end
  endtask

  // Reference model: outcome index (0 ok,1 undef,2 trap,3 redir), target (0 none,1 low,2 hyp)
  task automatic predict(input int enc_sel, input int lv, input bit wr, input logic [10:0] c,
                         output int oc, output int tgt, output string tag);
    bit vm, fg;
    oc = 1; tgt = 0; tag = "R4";
    vm = wr ? c[5] : c[4];
    fg = (wr ? c[7] : c[6]) && (!c[9] || c[8]);
    if (lv == 0) begin
      tag = "R5";
    end else if (enc_sel == 2) begin
      tag = "R4";
    end else if (enc_sel == 1) begin
      if (lv == 1) begin tag = "R6"; oc = (c[10] && c[1]) ? 2 : 1; end
      else begin tag = "R9"; oc = 0; tgt = 2; end
    end else if (lv == 1) begin
      tag = wr ? "R8" : "R7";
      if (!c[10])               begin oc = 0; tgt = 1; end
      else if (vm)              oc = 2;
      else if (fg)              oc = 2;
      else if (c[1] && c[2] && c[3]) oc = 3;
      else                      begin oc = 0; tgt = 1; end
    end else if (lv == 2) begin
      tag = "R9"; oc = 0; tgt = c[0] ? 2 : 1;
    end else begin
      tag = "R10"; oc = 0; tgt = 1;
    end
  endtask

  task automatic run_req(input int enc_sel, input logic [2:0] var_sel, input int lv,
                         input bit wr, input logic [63:0] wd, input logic [10:0] c);
    int oc, tgt;
    string tag;
    logic [63:0] exp_rd;
    predict(enc_sel, lv, wr, c, oc, tgt, tag);
    @(negedge clk);
    set_enc(enc_sel, var_sel);
    req_level = 2'(lv); req_write = wr; req_wdata = wd; ctl = c; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_rd = (oc == 0 && !wr) ? ((tgt == 2) ? model_hyp : model_low) : 64'd0;
    check(rsp_valid == 1'b1, "R2", "response valid one clock after accept", 64'(rsp_valid), 64'd1);
    check(rsp_status == (4'b0001 << oc), tag, "status", 64'(rsp_status), 64'(4'b0001 << oc));
    check(rsp_class == ((oc == 2) ? 6'h18 : 6'h00), "R3", "class", 64'(rsp_class),
          (oc == 2) ? 64'h18 : 64'h0);
    check(rsp_offset == ((oc == 3) ? 12'h210 : 12'h000), "R3", "offset", 64'(rsp_offset),
          (oc == 3) ? 64'h210 : 64'h0);
    check(rsp_rdata == exp_rd, "R11", "read data", rsp_rdata, exp_rd);
    if (oc == 0 && wr) begin
      if (tgt == 2) model_hyp = wd; else model_low = wd;
    end
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    logic [2:0] hs_status;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    // R1: both registers zero, read from level 3
    run_req(0, 3'd0, 3, 1'b0, 64'd0, 11'd0);
    run_req(1, 3'd0, 3, 1'b0, 64'd0, 11'd0);
    // R11: direct write then read of the hypervisor register
    run_req(1, 3'd0, 2, 1'b1, 64'hFEDC_BA98_7654_3210, 11'd0);
    run_req(1, 3'd0, 3, 1'b0, 64'd0, 11'd0);

    // R2: back-pressure, held response and a waiting request
    @(negedge clk);
    rsp_ready = 1'b0;
    set_enc(1, 3'd0); req_level = 2'd3; req_write = 1'b0; ctl = '0; req_valid = 1'b1;
    @(negedge clk);
    set_enc(0, 3'd0); req_level = 2'd0;
    hs_status = 3'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid && req_ready == 1'b0, "R2", "stall blocks request", 64'(req_ready), 64'd0);
      check(rsp_status == 4'b0001 && rsp_rdata == model_hyp, "R2", "held response",
            rsp_rdata, model_hyp);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_status == 4'b0010, "R2", "queued request after drain",
          64'(rsp_status), 64'b0010);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2", "response drained", 64'(rsp_valid), 64'd0);
    if (hs_status != 3'd0) check(1'b0, "R2", "unused", 64'd0, 64'd0);

    // Sweep: all controls x levels x encodings x read/write
    n = 0;
    for (int c = 0; c < 2048; c++) begin
      for (int lv = 0; lv < 4; lv++) begin
        for (int e = 0; e < 3; e++) begin
          for (int w = 0; w < 2; w++) begin
            n++;
            run_req(e, 3'(c) ^ 3'(lv), lv, w[0],
                    {32'(n) * 32'h9E37_79B1, 32'(n) ^ 32'hA5A5_0F0F}, 11'(c));
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule